// File: doc/BRIEF.md
# Clock-generator configuration write slave

This block is a write-only slave on a two-wire serial bus that owns the control registers of a clock synthesizer. A fast system clock samples the bus lines. A transaction opens with a start condition and an address byte, which must equal 8'hD2 with the direction bit included. A command byte and a byte-count byte follow, and after them come the data bytes. Each byte is acknowledged by holding SDA low for the ninth SCL pulse.

The first six data bytes land in a register bank, one byte at a time, as each byte completes. The bytes after that are acknowledged and thrown away. From the bank the block decodes the controls the synthesizer needs:
- the frequency code, taken from the external strap pins or from a serial field;
- the source of that code;
- the operating mode, which can turn spread spectrum on or float every clock output;
- six active-high clock enables.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: Bytes after the address are acknowledged and acted on only when the address byte is 8'hD2. Any other address gets no acknowledge, and no register changes until the next start.
- R2: Every byte is shifted in most significant bit first. The first bit sampled on an SCL rise becomes bit 7.
- R3: After a matching address, every byte gets an acknowledge. `sda_oe_o` goes high after the SCL fall that ends bit 8 and goes low after the SCL fall that ends the ninth pulse. It stays low during data bits.
- R4: The bytes arrive as address, command, count, then data. Data bytes 0..5 update control byte 0..5 on the eighth SCL rise of that byte. Data byte 6, data byte 7 and any later bytes are acknowledged and have no effect.
- R5: After reset, `clk_en_o` is all ones, `mode_o` is 0, `freq_src_o` is 0, and `freq_sel_o` follows `fs_pins_i`.
- R6: Byte 0 bits 1:0 give `mode_o`. Code 2'b10 raises `spread_en_o`. Code 2'b11 raises `outputs_hiz_o`. Codes 2'b00 and 2'b01 raise neither.
- R7: Byte 0 bit 3 drives `freq_src_o`. When it is 0, `freq_sel_o` equals `fs_pins_i`. When it is 1, `freq_sel_o` equals {bit 2, bit 6, bit 5, bit 4} of byte 0.
- R8: `clk_en_o[3:0]` comes from byte 1 bits 3:0, and `clk_en_o[5:4]` comes from byte 2 bits 6:5. A 0 disables that output.
- R9: Reserved positions are stored as 0 whatever is written: byte 0 bit 7, byte 1 bits 7:4, byte 2 bit 7, byte 2 bits 4:0, and all of bytes 3..5.
- R10: A stop or a repeated start in the middle of a byte drops the partial byte and keeps every byte already completed.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, SDA is released. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_oe_o | output | 1 | When high, pulls SDA low (acknowledge) |
| fs_pins_i | input | 4 | Frequency code from the strap pins |
| freq_sel_o | output | 4 | Frequency code in effect |
| freq_src_o | output | 1 | 1 when the serial field supplies the frequency code |
| mode_o | output | 2 | Operating-mode code |
| spread_en_o | output | 1 | Spread spectrum on |
| outputs_hiz_o | output | 1 | Float all clock outputs |
| clk_en_o | output | 6 | Per-output clock enables, active high |

## Verification
The bench builds the block with its defaults: address 8'hD2, six stored bytes out of eight mapped, and a two-stage synchronizer. It runs SCL at twenty system clocks per phase. With these values a ten-byte burst passes both the stored-byte limit and the mapped-byte limit, so the discard path is exercised after the last stored byte and again after the last mapped byte. The slow SCL leaves room for the synchronizer delay, so every acknowledge can be sampled in the middle of the ninth high phase. A behavioural model of the six bytes is compared with the decoded outputs on every clock, including the cycles in which the strap pins change.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_CMD, RX_CNT, RX_DATA, RX_SKIP
  } rx_state_e;

  // acknowledge phase: armed -> driving -> ninth pulse seen
  typedef enum logic [1:0] {
    ACK_NONE, ACK_ARM, ACK_LOW, ACK_HELD
  } ack_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;

  localparam logic [7:0] CTL0_MASK = 8'h7F;
  localparam logic [7:0] CTL1_MASK = 8'h0F;
  localparam logic [7:0] CTL2_MASK = 8'h60;
  localparam logic [7:0] CTL0_RST  = 8'h00;
  localparam logic [7:0] CTL1_RST  = 8'h0F;
  localparam logic [7:0] CTL2_RST  = 8'h60;

  localparam int unsigned SRC_BIT = 3;
  localparam int unsigned SEL_HI_BIT = 2;
endpackage

// File: rtl/twowire_sync_detect.sv
`timescale 1ns/1ps
module twowire_sync_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL is high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twowire_byte_rx.sv
`timescale 1ns/1ps
module twowire_byte_rx
  import clkcfg_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR     = 8'hD2,
  parameter int unsigned DATA_BYTES   = 8,
  parameter int unsigned STORED_BYTES = 6,
  parameter int unsigned IDX_W        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  localparam int unsigned CNT_W = $clog2(DATA_BYTES + 1);

  rx_state_e        state_q;
  ack_state_e       ack_q;
  logic [2:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic [CNT_W-1:0] data_idx_q;
  logic [7:0]       byte_next;
  logic             rx_active;

  assign byte_next = {shreg_q[6:0], sda_i};
  assign rx_active = (state_q != RX_IDLE) && (state_q != RX_SKIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      ack_q      <= ACK_NONE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      data_idx_q <= '0;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q    <= RX_ADDR;
        ack_q      <= ACK_NONE;
        bit_cnt_q  <= '0;
        data_idx_q <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q   <= RX_IDLE;
        ack_q     <= ACK_NONE;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (rx_active) begin
        unique case (ack_q)
          ACK_NONE: if (scl_rise_i) begin
            shreg_q   <= byte_next;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              if (state_q == RX_ADDR && byte_next != DEV_ADDR) begin
                state_q <= RX_SKIP;
              end else begin
                ack_q <= ACK_ARM;
                if (state_q == RX_DATA && int'(data_idx_q) < STORED_BYTES) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= IDX_W'(data_idx_q);
                  wr_data_o <= byte_next;
                end
              end
            end
          end
          ACK_ARM: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            ack_q    <= ACK_LOW;
          end
          ACK_LOW: if (scl_rise_i) ack_q <= ACK_HELD;
          ACK_HELD: if (scl_fall_i) begin
            sda_oe_o  <= 1'b0;
            ack_q     <= ACK_NONE;
            bit_cnt_q <= '0;
            unique case (state_q)
              RX_ADDR: state_q <= RX_CMD;
              RX_CMD:  state_q <= RX_CNT;
              RX_CNT:  state_q <= RX_DATA;
              default: if (int'(data_idx_q) < DATA_BYTES) data_idx_q <= data_idx_q + 1'b1;
            endcase
          end
          default: ack_q <= ACK_NONE;
        endcase
      end
    end
  end

  assert_skip_no_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_SKIP) |-> !sda_oe_o);

  assert_ack_steady_scl_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !start_i && !stop_i) |-> $stable(sda_oe_o));

  assert_write_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_idx_o) < STORED_BYTES));

  assert_write_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(scl_rise_i));

  assert_stop_releases_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
endmodule

// File: rtl/clkcfg_regbank.sv
`timescale 1ns/1ps
module clkcfg_regbank #(
  parameter int unsigned STORED_BYTES = 6,
  parameter int unsigned IDX_W        = 3,
  parameter logic [STORED_BYTES*8-1:0] RST_VAL = '0,
  parameter logic [STORED_BYTES*8-1:0] WR_MASK = '1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [7:0]                   wr_data_i,
  output logic [STORED_BYTES-1:0][7:0] regs_o
);
  for (genvar g = 0; g < STORED_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g] <= RST_VAL[g*8 +: 8] & WR_MASK[g*8 +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        regs_o[g] <= wr_data_i & WR_MASK[g*8 +: 8];
    end
  end

  assert_hold_without_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o & ~WR_MASK) == '0);
endmodule

// File: rtl/clkgen_cfg_slave.sv
`timescale 1ns/1ps
module clkgen_cfg_slave
  import clkcfg_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR     = 8'hD2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned DATA_BYTES   = 8,
  parameter int unsigned STORED_BYTES = 6   // at least 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] fs_pins_i,
  output logic [3:0] freq_sel_o,
  output logic       freq_src_o,
  output logic [1:0] mode_o,
  output logic       spread_en_o,
  output logic       outputs_hiz_o,
  output logic [5:0] clk_en_o
);
  localparam int unsigned IDX_W = (STORED_BYTES > 1) ? $clog2(STORED_BYTES) : 1;
  localparam int unsigned BANK_W = STORED_BYTES * 8;
  localparam logic [BANK_W-1:0] WR_MASK = BANK_W'({CTL2_MASK, CTL1_MASK, CTL0_MASK});
  localparam logic [BANK_W-1:0] RST_VAL = BANK_W'({CTL2_RST, CTL1_RST, CTL0_RST});

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [STORED_BYTES-1:0][7:0] regs;
  logic [7:0] ctl0, ctl1, ctl2;
  logic [3:0] sel_serial;
  logic unused_bits;

  twowire_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  twowire_byte_rx #(
    .DEV_ADDR(DEV_ADDR), .DATA_BYTES(DATA_BYTES),
    .STORED_BYTES(STORED_BYTES), .IDX_W(IDX_W)
  ) u_rx (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  clkcfg_regbank #(
    .STORED_BYTES(STORED_BYTES), .IDX_W(IDX_W),
    .RST_VAL(RST_VAL), .WR_MASK(WR_MASK)
  ) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .regs_o(regs)
  );

  assign ctl0 = regs[0];
  assign ctl1 = regs[1];
  assign ctl2 = regs[2];

  // serial code: bit 2 is the top bit, bits 6:4 the rest
  assign sel_serial    = {ctl0[SEL_HI_BIT], ctl0[6:4]};
  assign freq_src_o    = ctl0[SRC_BIT];
  assign freq_sel_o    = freq_src_o ? sel_serial : fs_pins_i;
  assign mode_o        = ctl0[1:0];
  assign spread_en_o   = (mode_e'(mode_o) == MODE_SPREAD);
  assign outputs_hiz_o = (mode_e'(mode_o) == MODE_HIZ);
  assign clk_en_o      = {ctl2[6:5], ctl1[3:0]};

  assign unused_bits = ^{regs[STORED_BYTES-1:3], ctl0[7], ctl1[7:4], ctl2[7], ctl2[4:0]};

  assert_mode_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spread_en_o && outputs_hiz_o));
endmodule

// File: tb/clkgen_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_tb_top;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic [3:0] fs = 4'h0;
  logic sda_oe, freq_src, spread_en, outputs_hiz;
  logic [3:0] freq_sel;
  logic [1:0] mode;
  logic [5:0] clk_en;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int hold_until = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;
  logic [7:0] m_reg [6];
  logic [7:0] q [$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  clkgen_cfg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .fs_pins_i(fs), .freq_sel_o(freq_sel), .freq_src_o(freq_src), .mode_o(mode),
    .spread_en_o(spread_en), .outputs_hiz_o(outputs_hiz), .clk_en_o(clk_en)
  );

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0: return 8'h7F;
      1: return 8'h0F;
      2: return 8'h60;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_sel();
    return m_reg[0][3] ? {m_reg[0][2], m_reg[0][6:4]} : fs;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(freq_src == m_reg[0][3], tag, "freq_src", int'(freq_src), int'(m_reg[0][3]));
    chk(freq_sel == exp_sel(), tag, "freq_sel", int'(freq_sel), int'(exp_sel()));
    chk(mode == m_reg[0][1:0], tag, "mode", int'(mode), int'(m_reg[0][1:0]));
    chk(spread_en == (m_reg[0][1:0] == 2'b10), tag, "spread_en", int'(spread_en), int'(m_reg[0][1:0] == 2'b10));
    chk(outputs_hiz == (m_reg[0][1:0] == 2'b11), tag, "outputs_hiz", int'(outputs_hiz), int'(m_reg[0][1:0] == 2'b11));
    chk(clk_en == {m_reg[2][6:5], m_reg[1][3:0]}, tag, "clk_en", int'(clk_en), int'({m_reg[2][6:5], m_reg[1][3:0]}));
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run_cmp && rst_n && cyc > hold_until) begin
      chk(freq_sel == exp_sel(), "R7", "freq_sel/clk", int'(freq_sel), int'(exp_sel()));
      chk({spread_en, outputs_hiz} == {m_reg[0][1:0] == 2'b10, m_reg[0][1:0] == 2'b11},
          "R6", "mode decode/clk", int'({spread_en, outputs_hiz}),
          int'({m_reg[0][1:0] == 2'b10, m_reg[0][1:0] == 2'b11}));
      chk(clk_en == {m_reg[2][6:5], m_reg[1][3:0]}, "R8", "clk_en/clk",
          int'(clk_en), int'({m_reg[2][6:5], m_reg[1][3:0]}));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL R4 watchdog act=%0d exp=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fs(input logic [3:0] v);
    @(negedge clk);
    fs = v;
    hold_until = cyc + 2;
  endtask

  task automatic tx_start();
    if (!scl) begin
      sda_drv = 1'b1; tick(HALF / 2);
      scl = 1'b1;     tick(HALF / 2);
    end
    sda_drv = 1'b0; tick(HALF);
    scl = 1'b0;     tick(HALF / 2);
  endtask

  task automatic tx_stop();
    sda_drv = 1'b0; tick(HALF / 2);
    scl = 1'b1;     tick(HALF / 2);
    sda_drv = 1'b1; tick(HALF);
    chk(sda_line == 1'b1, "R11", "sda released after stop", int'(sda_line), 1);
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; tick(HALF / 2);
      scl = 1'b1;     tick(HALF);
      scl = 1'b0;     tick(HALF / 2);
    end
  endtask

  // store_idx < 0: byte does not touch the model
  task automatic tx_byte(input logic [7:0] b, input bit exp_ack, input int store_idx, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(HALF / 2);
      scl = 1'b1;
      if (i == 0 && store_idx >= 0 && store_idx < 6) begin
        m_reg[store_idx] = b & wmask(store_idx);
        hold_until = cyc + 10;
      end
      chk(sda_oe == 1'b0, tag, "no drive in data bit", int'(sda_oe), 0);
      tick(HALF);
      scl = 1'b0; tick(HALF / 2);
    end
    sda_drv = 1'b1; tick(HALF / 2);
    scl = 1'b1;     tick(HALF / 2);
    chk(sda_line == !exp_ack, tag, "ack level", int'(sda_line), int'(!exp_ack));
    tick(HALF / 2);
    scl = 1'b0;     tick(HALF / 2);
  endtask

  task automatic tx_head(input logic [7:0] addr, input int cnt, input string tag);
    bit ok;
    ok = (addr == 8'hD2);
    tx_start();
    tx_byte(addr, ok, -1, tag);
    tx_byte(8'h00, ok, -1, tag);
    tx_byte(8'(cnt), ok, -1, tag);
  endtask

  task automatic txn(input logic [7:0] addr, input string tag);
    bit ok;
    ok = (addr == 8'hD2);
    tx_head(addr, q.size(), tag);
    foreach (q[k]) tx_byte(q[k], ok, ok ? k : -1, tag);
    tx_stop();
  endtask

  initial begin
    m_reg[0] = 8'h00; m_reg[1] = 8'h0F; m_reg[2] = 8'h60;
    m_reg[3] = 8'h00; m_reg[4] = 8'h00; m_reg[5] = 8'h00;
    fs = 4'h5;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R5: reset state
    check_all("R5");
    chk(sda_oe == 1'b0, "R5", "sda_oe after reset", int'(sda_oe), 0);
    run_cmp = 1'b1;

    // R3/R2: full eight-byte burst, spread mode, serial frequency code
    set_fs(4'h3);
    q = {8'h7A, 8'hF5, 8'hFF, 8'h11, 8'h22, 8'h33, 8'hAA, 8'h55};
    txn(8'hD2, "R3");
    tick(10);
    check_all("R2");
    chk(freq_sel == 4'h7, "R7", "serial code", int'(freq_sel), 7);
    chk(spread_en == 1'b1, "R6", "spread on", int'(spread_en), 1);
    chk(clk_en == 6'b110101, "R8", "enables", int'(clk_en), 'h35);

    // R1: wrong address and read direction are ignored
    q = {8'h03, 8'h00, 8'h00};
    txn(8'hD0, "R1");
    txn(8'hD3, "R1");
    tick(10);
    check_all("R1");

    // R6/R7/R9: float mode, strap pins select, reserved bit 7 ignored
    set_fs(4'hA);
    q = {8'h83};
    txn(8'hD2, "R3");
    tick(10);
    check_all("R9");
    chk(outputs_hiz == 1'b1 && spread_en == 1'b0, "R6", "float mode", int'({outputs_hiz, spread_en}), 2);
    chk(freq_sel == 4'hA, "R7", "strap code", int'(freq_sel), 'hA);
    set_fs(4'h6);
    tick(4);
    chk(freq_sel == 4'h6, "R7", "strap follows pins", int'(freq_sel), 6);

    // R6: reserved mode code raises neither control
    q = {8'h01};
    txn(8'hD2, "R3");
    tick(10);
    chk({outputs_hiz, spread_en} == 2'b00, "R6", "mode 01", int'({outputs_hiz, spread_en}), 0);
    check_all("R6");

    // R4/R8/R9: ten data bytes, extras acknowledged and dropped
    q = {8'h1C, 8'h00, 8'h9F, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hEE, 8'hDD};
    txn(8'hD2, "R4");
    tick(10);
    check_all("R4");
    chk(freq_sel == 4'h9, "R7", "serial code 9", int'(freq_sel), 9);
    chk(clk_en == 6'b000000, "R8", "all disabled", int'(clk_en), 0);

    // R10: stop in the middle of data byte 1
    tx_head(8'hD2, 2, "R10");
    tx_byte(8'h5C, 1'b1, 0, "R10");
    tx_bits(8'hFF, 4);
    tx_stop();
    tick(10);
    check_all("R10");
    chk(freq_sel == 4'hD, "R10", "completed byte kept", int'(freq_sel), 'hD);

    // R10/R11: repeated start mid-byte, then a fresh address phase
    tx_head(8'hD2, 2, "R11");
    tx_bits(8'hFF, 5);
    q = {8'h01, 8'h0A};
    txn(8'hD2, "R11");
    tick(10);
    check_all("R10");
    chk(clk_en == 6'b001010, "R8", "enables after restart", int'(clk_en), 'h0A);

    tick(20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule